// File: doc/BRIEF.md
# Reset Classification Controller

This block gathers reset requests from every initiator in the device and gives each one a reset class: power-on, hard or soft. The initiators are the active-low power-on input (the block's own `rst_ni`), a full-reset pin, a warm-reset pin, a software request bit, a set of watchdog timers and an emulation request. The class decides which reset domains are driven: the test/emulation domain, the reset-isolation domain and the main logic domain. It also decides whether the strobe that captures the device configuration pins fires.

Pin and watchdog requests are asynchronous. Each passes through a two-flop synchronizer. The winning request starts a reset that lasts at least a minimum number of cycles and is released on a clock edge. A small register port has three uses: it selects soft instead of hard for each reconfigurable initiator, it raises a software reset, and it reports the class and cause of the most recent reset.

Top module: `rst_class_ctrl`

## Requirements
- R1: A low level on `rst_ni` or a full-reset request gives a power-on reset. A power-on reset asserts `dbg_rst_o`, `iso_rst_o` and `core_rst_o`, and it clears the select register.
- R2: `cfg_latch_o` pulses for exactly one cycle in each power-on reset, in the cycle where the reset has been active for MIN_CYC-1 cycles. It never pulses during a hard or soft reset.
- R3: A hard reset asserts `core_rst_o` only. It can come from the warm pin, the software bit, any watchdog or the emulation request.
- R4: An emulation request always gives a hard reset, whatever the select register holds.
- R5: The select register is at address 1. Bit 0 is the warm pin, bit 1 is the software bit, and bit 2+i is watchdog i. A 1 selects soft and a 0 selects hard. The register resets to 0 and reads back as written.
- R6: A soft reset asserts `core_rst_o` only and leaves the select register unchanged. A hard reset clears the select register when it starts.
- R7: An asynchronous request that is high at clock edge k makes `core_rst_o` high after edge k+2.
- R8: An asserted reset lasts at least MIN_CYC cycles (16 by default). It is released at the first edge where that count is complete and no request is present. A request that stays present keeps the reset asserted.
- R9: Among requests present together, power-on beats hard and hard beats soft. Within one class, the lowest cause code wins. A stronger request that arrives during a weaker reset upgrades it and restarts the count.
- R10: The status register is at address 2. Bits [1:0] hold the class (1 soft, 2 hard, 3 power-on). The next bits hold the cause: 0 power-on pin, 1 full pin, 2 warm pin, 3 software, 4 emulation, 5+i watchdog i. The register updates at every reset start or upgrade and reads 3 after `rst_ni`.
- R11: Writing 1 to bit 0 of address 0 sets a pending software request, which reads back at bit 0 of that address. The request starts a reset at the next edge and clears when a reset starts.
- R12: Register writes are ignored while `core_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset pin, active low, asynchronous |
| full_rst_req_i | input | 1 | Full-reset pin request, asynchronous |
| warm_rst_req_i | input | 1 | Warm-reset pin request, asynchronous |
| emu_rst_req_i | input | 1 | Emulation reset request, asynchronous |
| wdog_rst_req_i | input | N_WDOG | Watchdog reset requests, asynchronous |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from the address |
| dbg_rst_o | output | 1 | Test/emulation domain reset |
| iso_rst_o | output | 1 | Reset-isolation domain reset |
| core_rst_o | output | 1 | Main logic domain reset |
| cfg_latch_o | output | 1 | Configuration pin capture strobe |

## Verification
The bench drives the following patterns:
- A single-cycle pulse from each initiator, first with the select register at 0 and then with it set. This separates the hard path from the soft path, checks that emulation ignores the select register, and checks which reset clears that register.
- Simultaneous requests of different classes and of the same class. These check the class priority and the cause order.
- A stronger request arriving during a weaker reset. This checks the upgrade and the restarted count.
- A request held for longer than the minimum width. This checks that release waits for the request to clear.
- A software write followed by a read-back, and writes made during a reset. These check the pending bit and that writes are dropped while the main domain is held.

A behavioural model runs alongside and compares all outputs on every cycle, which catches any error in latency, width and strobe placement.

// File: rtl/rst_cls_pkg.sv
package rst_cls_pkg;
  // Ordered by strength; numeric compare gives priority.
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_SOFT = 2'd1,
    RT_HARD = 2'd2,
    RT_POR  = 2'd3
  } rst_type_e;

  // Cause codes reported in status; order is the tie-break within a class.
  localparam int unsigned SRC_POR_PIN = 0;
  localparam int unsigned SRC_FULL    = 1;
  localparam int unsigned SRC_WARM    = 2;
  localparam int unsigned SRC_SW      = 3;
  localparam int unsigned SRC_EMU     = 4;
  localparam int unsigned SRC_WDOG0   = 5;

  // Soft-select bit positions.
  localparam int unsigned SEL_WARM  = 0;
  localparam int unsigned SEL_SW    = 1;
  localparam int unsigned SEL_WDOG0 = 2;

  // Register addresses.
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SEL  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/rst_cls_sync.sv
module rst_cls_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rst_cls_prio.sv
module rst_cls_prio
  import rst_cls_pkg::*;
#(
  parameter int unsigned N_WDOG = 4,
  parameter int unsigned CW     = 4,
  localparam int unsigned NSRC  = SRC_WDOG0 + N_WDOG,
  localparam int unsigned NSEL  = SEL_WDOG0 + N_WDOG
) (
  input  logic              full_i,
  input  logic              warm_i,
  input  logic              sw_i,
  input  logic              emu_i,
  input  logic [N_WDOG-1:0] wdog_i,
  input  logic [NSEL-1:0]   soft_sel_i,
  output rst_type_e         type_o,
  output logic [CW-1:0]     cause_o
);
  rst_type_e src_t [NSRC];

  assign src_t[SRC_POR_PIN] = RT_NONE;  // handled by the async reset itself
  assign src_t[SRC_FULL]    = full_i ? RT_POR : RT_NONE;
  assign src_t[SRC_WARM]    = !warm_i ? RT_NONE
                            : (soft_sel_i[SEL_WARM] ? RT_SOFT : RT_HARD);
  assign src_t[SRC_SW]      = !sw_i ? RT_NONE
                            : (soft_sel_i[SEL_SW] ? RT_SOFT : RT_HARD);
  assign src_t[SRC_EMU]     = emu_i ? RT_HARD : RT_NONE;

  for (genvar i = 0; i < N_WDOG; i++) begin : g_wdog
    assign src_t[SRC_WDOG0+i] = !wdog_i[i] ? RT_NONE
                              : (soft_sel_i[SEL_WDOG0+i] ? RT_SOFT : RT_HARD);
  end

  rst_type_e       best_t;
  logic [CW-1:0]   best_c;

  // Strict compare keeps the lowest cause index within a class.
  always_comb begin
    best_t = RT_NONE;
    best_c = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (src_t[i] > best_t) begin
        best_t = src_t[i];
        best_c = CW'(i);
      end
    end
  end

  assign type_o  = best_t;
  assign cause_o = best_c;

  // R4: emulation never resolves below hard
  always_comb begin
    if (emu_i) begin
      a_r4_emu_hard: assert (type_o == RT_HARD || type_o == RT_POR);
    end
  end
endmodule

// File: rtl/rst_cls_seq.sv
module rst_cls_seq
  import rst_cls_pkg::*;
#(
  parameter int unsigned MIN_CYC = 16,
  parameter int unsigned CW      = 4,
  localparam int unsigned CNTW   = $clog2(MIN_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rst_type_e     req_type_i,
  input  logic [CW-1:0] req_cause_i,
  output logic          act_o,
  output rst_type_e     type_o,
  output logic          evt_o,
  output rst_type_e     evt_type_o,
  output logic [CW-1:0] evt_cause_o,
  output logic          latch_o
);
  localparam logic [CNTW-1:0] CNT_LAST  = CNTW'(MIN_CYC - 1);
  localparam logic [CNTW-1:0] CNT_LATCH = CNTW'(MIN_CYC - 2);

  logic            act_q;
  rst_type_e       typ_q;
  logic [CNTW-1:0] cnt_q;
  logic            evt;

  // Start from idle, or upgrade to a strictly stronger class.
  always_comb begin
    evt = 1'b0;
    if (!act_q) evt = (req_type_i != RT_NONE);
    else        evt = (req_type_i > typ_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      typ_q <= RT_POR;
      cnt_q <= '0;
    end else if (evt) begin
      act_q <= 1'b1;
      typ_q <= req_type_i;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q != CNT_LAST)          cnt_q <= cnt_q + CNTW'(1);
      else if (req_type_i == RT_NONE) act_q <= 1'b0;
    end
  end

  assign act_o       = act_q;
  assign type_o      = typ_q;
  assign evt_o       = evt;
  assign evt_type_o  = req_type_i;
  assign evt_cause_o = req_cause_i;
  assign latch_o     = act_q && (typ_q == RT_POR) && (cnt_q == CNT_LATCH);

  // R8: release only after the full minimum count
  a_r8_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(cnt_q) == CNT_LAST));

  // R9: class never weakens while a reset is held
  a_r9_no_downgrade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q)) |-> (typ_q >= $past(typ_q)));

  // R2: strobe is a single-cycle pulse
  a_r2_latch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
endmodule

// File: rtl/rst_cls_regs.sv
module rst_cls_regs
  import rst_cls_pkg::*;
#(
  parameter int unsigned N_WDOG = 4,
  parameter int unsigned CW     = 4,
  parameter int unsigned DW     = 8,
  localparam int unsigned NSEL  = SEL_WDOG0 + N_WDOG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            busy_i,
  input  logic            evt_i,
  input  rst_type_e       evt_type_i,
  input  logic [CW-1:0]   evt_cause_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NSEL-1:0] soft_sel_o,
  output logic            sw_req_o
);
  logic [NSEL-1:0] soft_sel_q;
  logic            sw_req_q;
  rst_type_e       st_type_q;
  logic [CW-1:0]   st_cause_q;
  logic            wr_ok;

  assign wr_ok = we_i && !busy_i && !evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_sel_q <= '0;
      sw_req_q   <= 1'b0;
      st_type_q  <= RT_POR;
      st_cause_q <= CW'(SRC_POR_PIN);
    end else if (evt_i) begin
      st_type_q  <= evt_type_i;
      st_cause_q <= evt_cause_i;
      sw_req_q   <= 1'b0;
      if (evt_type_i >= RT_HARD) soft_sel_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_CTRL && wdata_i[0]) sw_req_q   <= 1'b1;
      if (addr_i == ADDR_SEL)                soft_sel_q <= wdata_i[NSEL-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = DW'(sw_req_q);
      ADDR_SEL:  rdata_o = DW'(soft_sel_q);
      ADDR_STAT: rdata_o = DW'({st_cause_q, st_type_q});
      default:   rdata_o = '0;
    endcase
  end

  assign soft_sel_o = soft_sel_q;
  assign sw_req_o   = sw_req_q;

  // R6: hard or stronger start clears the select register
  a_r6_sel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && evt_type_i >= RT_HARD) |=> (soft_sel_q == '0));

  // R11: pending software request drops once a reset starts
  a_r11_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !sw_req_q);

  // R12: select register frozen while a reset holds without a new start
  a_r12_busy_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !evt_i) |=> $stable(soft_sel_q));
endmodule

// File: rtl/rst_class_ctrl.sv
module rst_class_ctrl
  import rst_cls_pkg::*;
#(
  parameter int unsigned N_WDOG  = 4,
  parameter int unsigned MIN_CYC = 16,
  parameter int unsigned DW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_rst_req_i,
  input  logic              warm_rst_req_i,
  input  logic              emu_rst_req_i,
  input  logic [N_WDOG-1:0] wdog_rst_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              dbg_rst_o,
  output logic              iso_rst_o,
  output logic              core_rst_o,
  output logic              cfg_latch_o
);
  localparam int unsigned NSRC    = SRC_WDOG0 + N_WDOG;
  localparam int unsigned CW      = $clog2(NSRC);
  localparam int unsigned NSEL    = SEL_WDOG0 + N_WDOG;
  localparam int unsigned ASYNC_W = 3 + N_WDOG;

  logic [ASYNC_W-1:0] async_raw, async_syn;
  logic [NSEL-1:0]    soft_sel;
  logic               sw_req;
  rst_type_e          req_type, cur_type, evt_type;
  logic [CW-1:0]      req_cause, evt_cause;
  logic               act, evt, latch;

  assign async_raw = {wdog_rst_req_i, emu_rst_req_i, warm_rst_req_i, full_rst_req_i};

  rst_cls_sync #(.W(ASYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_syn)
  );

  rst_cls_prio #(.N_WDOG(N_WDOG), .CW(CW)) u_prio (
    .full_i     (async_syn[0]),
    .warm_i     (async_syn[1]),
    .sw_i       (sw_req),
    .emu_i      (async_syn[2]),
    .wdog_i     (async_syn[ASYNC_W-1:3]),
    .soft_sel_i (soft_sel),
    .type_o     (req_type),
    .cause_o    (req_cause)
  );

  rst_cls_seq #(.MIN_CYC(MIN_CYC), .CW(CW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_type_i  (req_type),
    .req_cause_i (req_cause),
    .act_o       (act),
    .type_o      (cur_type),
    .evt_o       (evt),
    .evt_type_o  (evt_type),
    .evt_cause_o (evt_cause),
    .latch_o     (latch)
  );

  rst_cls_regs #(.N_WDOG(N_WDOG), .CW(CW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (act),
    .evt_i       (evt),
    .evt_type_i  (evt_type),
    .evt_cause_i (evt_cause),
    .rdata_o     (reg_rdata_o),
    .soft_sel_o  (soft_sel),
    .sw_req_o    (sw_req)
  );

  // Domain map: power-on hits all, hard/soft only the main domain.
  assign core_rst_o  = act;
  assign iso_rst_o   = act && (cur_type == RT_POR);
  assign dbg_rst_o   = act && (cur_type == RT_POR);
  assign cfg_latch_o = latch;

  // R2: strobe only inside a power-on reset
  a_r2_latch_por: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_latch_o |-> (dbg_rst_o && iso_rst_o && core_rst_o));

  // R7: an idle-to-active start not from software traces to a request three edges back
  a_r7_async_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(core_rst_o) && !$past(sw_req)) |-> ($past(async_raw, 3) != '0));
endmodule

// File: tb/tb_rst_class_ctrl.sv
module tb_rst_class_ctrl;
  localparam int NW   = 4;
  localparam int MINC = 16;
  localparam int DW   = 8;
  localparam int NSEL = 2 + NW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          full = 1'b0, warm = 1'b0, emu = 1'b0;
  logic [NW-1:0] wdog = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd2;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          dbg, iso, core, latch;

  rst_class_ctrl #(.N_WDOG(NW), .MIN_CYC(MINC), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .full_rst_req_i(full), .warm_rst_req_i(warm), .emu_rst_req_i(emu),
    .wdog_rst_req_i(wdog),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dbg_rst_o(dbg), .iso_rst_o(iso), .core_rst_o(core), .cfg_latch_o(latch)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit            m_act = 1'b1;
  int            m_typ = 3, m_cnt = 0, m_stt = 3, m_stc = 0, m_cfg = 0;
  bit            m_swp = 1'b0;
  logic [NW+2:0] m_s1 = '0, m_s2 = '0;

  function automatic int sel_type(input int bitpos);
    return ((m_cfg >> bitpos) & 1) != 0 ? 1 : 2;
  endfunction

  function automatic int src_type(input int s);
    case (s)
      1:       return m_s2[0] ? 3 : 0;
      2:       return m_s2[1] ? sel_type(0) : 0;
      3:       return m_swp   ? sel_type(1) : 0;
      4:       return m_s2[2] ? 2 : 0;
      default: return m_s2[3 + (s - 5)] ? sel_type(2 + (s - 5)) : 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int rq;
    int rc;
    bit ev;
    bit act_old;
    if (!rst_n) begin
      m_act = 1'b1; m_typ = 3; m_cnt = 0; m_stt = 3; m_stc = 0;
      m_cfg = 0; m_swp = 1'b0; m_s1 = '0; m_s2 = '0;
    end else begin
      rq = 0; rc = 0;
      for (int s = 1; s < 5 + NW; s++) begin
        if (src_type(s) > rq) begin rq = src_type(s); rc = s; end
      end
      act_old = m_act;
      ev = 1'b0;
      if (!m_act)            ev = (rq != 0);
      else if (rq > m_typ)   ev = 1'b1;
      else if (m_cnt < MINC - 1) m_cnt++;
      else if (rq == 0)      m_act = 1'b0;
      if (ev) begin
        m_act = 1'b1; m_typ = rq; m_cnt = 0; m_stt = rq; m_stc = rc; m_swp = 1'b0;
        if (rq >= 2) m_cfg = 0;
      end else if (!act_old && we) begin
        if (addr == 2'd0 && wdata[0]) m_swp = 1'b1;
        if (addr == 2'd1) m_cfg = int'(wdata[NSEL-1:0]);
      end
      m_s2 = m_s1;
      m_s1 = {wdog, emu, warm, full};
    end
  end

  function automatic int exp_rd();
    case (addr)
      2'd0:    return int'(m_swp);
      2'd1:    return m_cfg;
      2'd2:    return m_stc * 4 + m_stt;
      default: return 0;
    endcase
  endfunction

  // ---------------- per-cycle comparison ----------------
  int run = 0, last_run = 0, latch_cnt = 0;

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R8 core_rst", int'(core), int'(m_act));
      chk("R1 dbg_rst", int'(dbg), int'(m_act && m_typ == 3));
      chk("R1 iso_rst", int'(iso), int'(m_act && m_typ == 3));
      chk("R2 cfg_latch", int'(latch), int'(m_act && m_typ == 3 && m_cnt == MINC - 2));
      chk("R10 rdata", int'(rdata), exp_rd());
      if (core) run++;
      else if (run != 0) begin last_run = run; run = 0; end
      if (latch) latch_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic pulse(input logic [NW+2:0] m);
    @(negedge clk); {wdog, emu, warm, full} = m;
    @(negedge clk); {wdog, emu, warm, full} = '0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (core) @(negedge clk);
  endtask

  localparam logic [NW+2:0] P_FULL = 1 << 0;
  localparam logic [NW+2:0] P_WARM = 1 << 1;
  localparam logic [NW+2:0] P_EMU  = 1 << 2;

  initial begin
    int v;
    int lc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();
    rd(2'd2, v); chk("R10 status after power-on", v, 3);
    rd(2'd1, v); chk("R5 select reset value", v, 0);

    // warm pin, hard, with latency check
    lc0 = latch_cnt;
    @(negedge clk); warm = 1'b1;
    @(posedge clk); #2 chk("R7 not yet at edge k", int'(core), 0);
    @(negedge clk); warm = 1'b0;
    @(posedge clk); #2 chk("R7 not yet at edge k+1", int'(core), 0);
    @(posedge clk); #2 chk("R7 asserted after edge k+2", int'(core), 1);
    wait_idle();
    chk("R8 pulse stretched to minimum", last_run, MINC);
    rd(2'd2, v); chk("R3 warm hard status", v, 2 * 4 + 2);
    chk("R2 no strobe on hard", latch_cnt - lc0, 0);

    // warm pin switched to soft
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R5 select readback", v, 1);
    pulse(P_WARM);
    wait_idle();
    rd(2'd2, v); chk("R6 warm soft status", v, 2 * 4 + 1);
    rd(2'd1, v); chk("R6 soft keeps select", v, 1);
    chk("R8 soft width", last_run, MINC);

    // emulation ignores select, hard clears it
    wr(2'd1, 8'h3F);
    pulse(P_EMU);
    wait_idle();
    rd(2'd2, v); chk("R4 emulation is hard", v, 4 * 4 + 2);
    rd(2'd1, v); chk("R6 hard clears select", v, 0);

    // watchdog 0 as soft
    wr(2'd1, 8'h04);
    pulse(P_EMU << 1);
    wait_idle();
    rd(2'd2, v); chk("R5 watchdog0 soft status", v, 5 * 4 + 1);

    // software request
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'h01;
    @(posedge clk); #2 chk("R11 pending bit readback", int'(rdata), 1);
    @(negedge clk); we = 1'b0; addr = 2'd2;
    wait_idle();
    rd(2'd2, v); chk("R11 software hard status", v, 3 * 4 + 2);
    rd(2'd0, v); chk("R11 pending cleared", v, 0);

    // writes during a reset are dropped
    pulse(P_WARM);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h3F);
    wait_idle();
    rd(2'd1, v); chk("R12 write while busy ignored", v, 0);

    // class priority: soft warm + hard watchdog1
    wr(2'd1, 8'h01);
    pulse(P_WARM | (P_EMU << 2));
    wait_idle();
    rd(2'd2, v); chk("R9 hard beats soft", v, 6 * 4 + 2);

    // same class: lowest cause wins
    pulse((P_EMU << 1) | (P_EMU << 3));
    wait_idle();
    rd(2'd2, v); chk("R9 lowest cause in class", v, 5 * 4 + 2);

    // upgrade soft to hard mid-reset
    wr(2'd1, 8'h01);
    pulse(P_WARM);
    repeat (6) @(negedge clk);
    pulse(P_EMU);
    wait_idle();
    chk("R9 upgrade restarts count", int'(last_run > MINC), 1);
    rd(2'd2, v); chk("R9 upgraded status", v, 4 * 4 + 2);

    // full pin gives power-on
    lc0 = latch_cnt;
    pulse(P_FULL);
    wait_idle();
    chk("R2 one strobe per power-on", latch_cnt - lc0, 1);
    rd(2'd2, v); chk("R1 full pin status", v, 1 * 4 + 3);
    chk("R8 power-on width", last_run, MINC);

    // held request keeps reset asserted
    @(negedge clk); warm = 1'b1;
    repeat (40) @(negedge clk);
    warm = 1'b0;
    wait_idle();
    chk("R8 held request width", last_run, 40);

    // mid-run power-on pin
    wr(2'd1, 8'h10);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();
    rd(2'd2, v); chk("R10 status after pin reset", v, 3);
    rd(2'd1, v); chk("R1 pin reset clears select", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule